// File: doc/BRIEF.md
# One-Time-Programmable Fuse Access Controller

This block sits between a simple register bus and an array of one-time-programmable fuse words. Software uses it to fetch one or more fuse words into read-data registers, to blow bits in a single fuse word, and to copy every fuse word into shadow registers in one bulk pass. Each fuse access is framed in time by programmable counts: a relax period on each side of the active strobe, a strobe length that differs for reads and for programming, and a settle time after the operation during which the controller stays busy.

Programming is guarded. The write-unlock field of the control register must hold the key 0x3E77 before a write to the data register launches a program, and the field empties itself after every program attempt. The controller handles one operation at a time. An attempt to start another while busy is dropped and raises a sticky error flag. Per-operation results (program failure, locked word, uncorrectable read data) come back as sticky status flags that software clears by writing ones to a clear alias. The analog fuse macro is replaced by a behavioural array: word i powers up holding i×0x01010101, blowing ORs the data into the word, a word can be programmed once, word 15 is locked and word 6 carries a bad check bit.

Top module: `fuse_sequencer`

## Requirements
- R1: With CTRL[31:16] equal to 0x3E77, a write to DATA (offset 5) ORs the written value into the fuse word addressed by CTRL[3:0]. Offsets are CTRL 0, CTRL_SET 1 and CTRL_CLR 2.
- R2: A write that would start an operation while busy is ignored and sets STATUS[1]. Such writes are DATA, READ_CTRL (offset 4) with bit 0 set, and CTRL or CTRL_SET with bit 12 set. STATUS[1] is sticky until a one is written to bit 1 of STATUS_CLR (offset 7).
- R3: Writing bit 12 through CTRL or CTRL_SET copies every fuse word into the shadow registers, which sit at offsets 0x20+i. Bit 12 reads back 1 until the whole operation ends, then clears itself. Busy stays high throughout. Shadows change only through this reload.
- R4: TIMING (offset 3) holds the wait count W in [7:0], the relax count R in [11:8], the read strobe count SR in [19:12] and the program strobe count SP in [27:20]. Reads and reloads pulse readStrobe using SR. Programs pulse progStrobe using SP.
- R5: Each word access lasts S+1 cycles. Its first and last R+1 cycles are relax, so the strobe is high for S+1−2(R+1) cycles, starting R+1 cycles after the access begins.
- R6: Writing READ_CTRL with bit 0 set reads N+1 words, where N is READ_CTRL[4]. The words come from consecutive addresses starting at CTRL[3:0], wrapping modulo 16. Word k lands in the read-data register at offset 8+k. Bit 0 clears itself when the read ends.
- R7: A program to a locked word sets STATUS[3]. A program to a word that was already programmed sets STATUS[2]. In both cases the word is left unchanged. Both flags clear through STATUS_CLR bits 3 and 2.
- R8: STATUS[4+k] is set when returned word k fails its stored check, and is cleared through STATUS_CLR bit 4+k.
- R9: CTRL_SET ORs the written bits into the address and unlock fields. CTRL_CLR clears them. A plain write to CTRL replaces both fields.
- R10: CTRL[31:16] reads zero after every program operation, whatever its result.
- R11: Busy (port busy and STATUS[0]) lasts words×(S+1)+(W+1) cycles from the launching write.
- R12: A DATA write without the key does not start an operation, leaves every fuse word unchanged and sets STATUS[1].
- R13: After reset, CTRL, READ_CTRL, STATUS and every shadow register read zero, and TIMING reads 0x00903001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 6 | Register word offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr (combinational) |
| busy | output | 1 | Operation in progress |
| readStrobe | output | 1 | Active read strobe to the fuse array |
| progStrobe | output | 1 | Active program strobe to the fuse array |

## Verification
On every cycle the assertions check the following. The fuse contents never change outside a program word step. No operation is launched while busy. The reload bit is never set while the controller is idle. The unlock field is empty after each program step. An uncorrectable-data flag only rises right after a read word step. Exact cycle counts need the bench's scenarios: strobe width, relax offset and busy length, swept over relax, strobe and wait values. So do the data results: read words with address wrap, program OR results, program-fail and locked outcomes, and shadow contents after a reload. The bench also shows that overlapped writes are dropped.

// File: rtl/fuse_pkg.sv
`timescale 1ns/1ps
package fuse_pkg;
  typedef enum logic [1:0] {OP_NONE = 2'd0, OP_READ = 2'd1, OP_PROG = 2'd2, OP_LOAD = 2'd3} opKind_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic busy;
    logic wordDone;  // last cycle of one word access
    logic opEnd;     // last cycle of the settle period
  } ctlStrobe_t;

  localparam logic [15:0] UNLOCK_KEY = 16'h3E77;
  localparam int RELOAD_BIT = 12;
endpackage

// File: rtl/fuse_control.sv
`timescale 1ns/1ps
module fuse_control
  import fuse_pkg::*;
#(
  parameter int STROBE_W = 8,
  parameter int RELAX_W  = 4,
  parameter int WAIT_W   = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  opKind_t             launchKind,
  input  logic                lastWord,
  input  logic [STROBE_W-1:0] rdLen,
  input  logic [STROBE_W-1:0] progLen,
  input  logic [RELAX_W-1:0]  relaxLen,
  input  logic [WAIT_W-1:0]   waitLen,
  output ctlStrobe_t          ctl,
  output logic                readStrobe,
  output logic                progStrobe
);
  localparam int CNT_W = ((STROBE_W > WAIT_W) ? STROBE_W : WAIT_W) + 2;

  typedef enum logic [1:0] {S_IDLE, S_STROBE, S_WAIT} state_t;

  state_t           state;
  opKind_t          kind;
  logic [CNT_W-1:0] step;
  logic [CNT_W-1:0] strobeLen;
  logic [CNT_W-1:0] relaxCycles;
  logic             strobeEnd;
  logic             waitEnd;
  logic             inWindow;

  always_comb begin
    strobeLen   = (kind == OP_PROG) ? CNT_W'(progLen) : CNT_W'(rdLen);
    relaxCycles = CNT_W'(relaxLen) + CNT_W'(1);
    strobeEnd   = (state == S_STROBE) && (step == strobeLen);
    waitEnd     = (state == S_WAIT) && (step == CNT_W'(waitLen));
    inWindow    = (step >= relaxCycles) && ((step + relaxCycles) <= strobeLen);
    readStrobe  = (state == S_STROBE) && inWindow && (kind != OP_PROG);
    progStrobe  = (state == S_STROBE) && inWindow && (kind == OP_PROG);
    ctl.busy     = (state != S_IDLE);
    ctl.wordDone = strobeEnd;
    ctl.opEnd    = waitEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      kind  <= OP_NONE;
      step  <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (launchKind != OP_NONE) begin
          state <= S_STROBE;
          kind  <= launchKind;
          step  <= '0;
        end
        S_STROBE: if (strobeEnd) begin
          step <= '0;
          if (lastWord) state <= S_WAIT;
        end else begin
          step <= step + CNT_W'(1);
        end
        S_WAIT: if (waitEnd) begin
          state <= S_IDLE;
          kind  <= OP_NONE;
        end else begin
          step <= step + CNT_W'(1);
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: the datapath never hands over a launch while an operation runs
  a_r2_no_launch_busy: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busy |-> launchKind == OP_NONE);
endmodule

// File: rtl/fuse_datapath.sv
`timescale 1ns/1ps
module fuse_datapath
  import fuse_pkg::*;
#(
  parameter int FUSE_WORDS = 16,
  parameter int READ_WORDS = 2,
  parameter int BUS_AW     = 6,
  parameter logic [FUSE_WORDS-1:0] LOCKED_MASK  = {1'b1, {(FUSE_WORDS-1){1'b0}}},
  parameter logic [FUSE_WORDS-1:0] CORRUPT_MASK = FUSE_WORDS'(1) << 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  ctlStrobe_t        ctl,
  output opKind_t           launchKind,
  output logic              lastWord,
  output logic [7:0]        tRd,
  output logic [7:0]        tProg,
  output logic [3:0]        tRelax,
  output logic [7:0]        tWait
);
  localparam int ADDR_W = $clog2(FUSE_WORDS);
  localparam int NUM_W  = (READ_WORDS > 1) ? $clog2(READ_WORDS) : 1;
  localparam logic [BUS_AW-1:0] A_CTRL = BUS_AW'(0), A_SET = BUS_AW'(1), A_CLR = BUS_AW'(2),
    A_TIME = BUS_AW'(3), A_RDCTL = BUS_AW'(4), A_DATA = BUS_AW'(5), A_STAT = BUS_AW'(6),
    A_STCLR = BUS_AW'(7);
  localparam int RDATA_BASE = 8;
  localparam int SHADOW_BASE = 32;

  logic [ADDR_W-1:0] ctrlAddr, opAddr, wordCnt, curAddr;
  logic [15:0]       unlockKey;
  logic              reloadBit, readFuse, errFlag, progFail, lockedFlag;
  logic [NUM_W-1:0]  readNum, rdIdx;
  logic [31:0]       dataReg;
  logic [READ_WORDS-1:0] ded;
  logic [READ_WORDS-1:0][31:0] readData;
  logic [FUSE_WORDS-1:0][31:0] shadow, fuseData;
  logic [FUSE_WORDS-1:0] fuseChk, fuseUsed;
  opKind_t opKindQ;

  logic wrCtrl, wrSet, wrClr, wrTime, wrRdCtl, wrData, wrStClr;
  logic wantLoad, wantRead, reject, keyOk, errSet, chkBad;
  logic isProgDone, isReadDone, isLoadDone;
  logic unusedBits;

  assign unusedBits = ^{busWdata[15:13], busWdata[11:ADDR_W]};

  always_comb begin
    wrCtrl   = busWr && busAddr == A_CTRL;
    wrSet    = busWr && busAddr == A_SET;
    wrClr    = busWr && busAddr == A_CLR;
    wrTime   = busWr && busAddr == A_TIME;
    wrRdCtl  = busWr && busAddr == A_RDCTL;
    wrData   = busWr && busAddr == A_DATA;
    wrStClr  = busWr && busAddr == A_STCLR;
    wantLoad = (wrCtrl || wrSet) && busWdata[RELOAD_BIT];
    wantRead = wrRdCtl && busWdata[0];
    reject   = (wantLoad || wantRead || wrData) && ctl.busy;
    keyOk    = unlockKey == UNLOCK_KEY;
    errSet   = reject || (wrData && !ctl.busy && !keyOk);
    if (ctl.busy)                 launchKind = OP_NONE;
    else if (wantLoad)            launchKind = OP_LOAD;
    else if (wantRead)            launchKind = OP_READ;
    else if (wrData && keyOk)     launchKind = OP_PROG;
    else                          launchKind = OP_NONE;
    curAddr    = opAddr + wordCnt;
    rdIdx      = wordCnt[NUM_W-1:0];
    chkBad     = (^fuseData[curAddr]) != fuseChk[curAddr];
    isProgDone = ctl.wordDone && opKindQ == OP_PROG;
    isReadDone = ctl.wordDone && opKindQ == OP_READ;
    isLoadDone = ctl.wordDone && opKindQ == OP_LOAD;
    unique case (opKindQ)
      OP_READ: lastWord = wordCnt == ADDR_W'(readNum);
      OP_LOAD: lastWord = wordCnt == ADDR_W'(FUSE_WORDS - 1);
      default: lastWord = 1'b1;
    endcase
  end

  // control register: address, unlock key, reload trigger
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlAddr <= '0; unlockKey <= '0; reloadBit <= 1'b0;
    end else begin
      if (!reject) begin
        if (wrCtrl) begin
          ctrlAddr <= busWdata[ADDR_W-1:0];
          unlockKey <= busWdata[31:16];
        end else if (wrSet) begin
          ctrlAddr <= ctrlAddr | busWdata[ADDR_W-1:0];
          unlockKey <= unlockKey | busWdata[31:16];
        end else if (wrClr) begin
          ctrlAddr <= ctrlAddr & ~busWdata[ADDR_W-1:0];
          unlockKey <= unlockKey & ~busWdata[31:16];
        end
        if (wantLoad) reloadBit <= 1'b1;
      end
      if (isProgDone) unlockKey <= '0;
      if (ctl.opEnd && opKindQ == OP_LOAD) reloadBit <= 1'b0;
    end
  end

  // timing, read control, data
  always_ff @(posedge clk) begin
    if (!rstN) begin
      tWait <= 8'd1; tRelax <= 4'd0; tRd <= 8'd3; tProg <= 8'd9;
      readFuse <= 1'b0; readNum <= '0; dataReg <= '0;
    end else begin
      if (wrTime) begin
        tWait <= busWdata[7:0]; tRelax <= busWdata[11:8];
        tRd <= busWdata[19:12]; tProg <= busWdata[27:20];
      end
      if (wrRdCtl && !reject) begin
        readFuse <= busWdata[0];
        readNum  <= busWdata[4 +: NUM_W];
      end
      if (ctl.opEnd && opKindQ == OP_READ) readFuse <= 1'b0;
      if (launchKind == OP_PROG) dataReg <= busWdata;
    end
  end

  // sticky status flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      errFlag <= 1'b0; progFail <= 1'b0; lockedFlag <= 1'b0; ded <= '0;
    end else begin
      if (wrStClr) begin
        errFlag    <= errFlag & ~busWdata[1];
        progFail   <= progFail & ~busWdata[2];
        lockedFlag <= lockedFlag & ~busWdata[3];
        ded        <= ded & ~busWdata[4 +: READ_WORDS];
      end
      if (errSet) errFlag <= 1'b1;
      if (isProgDone && LOCKED_MASK[curAddr]) lockedFlag <= 1'b1;
      else if (isProgDone && fuseUsed[curAddr]) progFail <= 1'b1;
      for (int k = 0; k < READ_WORDS; k++)
        if (isReadDone && rdIdx == NUM_W'(k) && chkBad) ded[k] <= 1'b1;
    end
  end

  // operation bookkeeping, read results, shadows
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opKindQ <= OP_NONE; opAddr <= '0; wordCnt <= '0;
      readData <= '0; shadow <= '0;
    end else begin
      if (launchKind != OP_NONE) begin
        opKindQ <= launchKind;
        opAddr  <= (launchKind == OP_LOAD) ? '0 : ctrlAddr;
        wordCnt <= '0;
      end else if (ctl.wordDone) begin
        wordCnt <= wordCnt + ADDR_W'(1);
      end
      for (int k = 0; k < READ_WORDS; k++)
        if (isReadDone && rdIdx == NUM_W'(k)) readData[k] <= fuseData[curAddr];
      if (isLoadDone) shadow[curAddr] <= fuseData[curAddr];
    end
  end

  // behavioural fuse array
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < FUSE_WORDS; i++) begin
        fuseData[i] <= 32'h0101_0101 * 32'(i);
        fuseChk[i]  <= (^(32'h0101_0101 * 32'(i))) ^ CORRUPT_MASK[i];
        fuseUsed[i] <= 1'b0;
      end
    end else if (isProgDone && !LOCKED_MASK[curAddr] && !fuseUsed[curAddr]) begin
      fuseData[curAddr] <= fuseData[curAddr] | dataReg;
      fuseChk[curAddr]  <= ^(fuseData[curAddr] | dataReg);
      fuseUsed[curAddr] <= 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (busAddr)
      A_CTRL: begin
        busRdata[ADDR_W-1:0] = ctrlAddr;
        busRdata[RELOAD_BIT] = reloadBit;
        busRdata[31:16]      = unlockKey;
      end
      A_TIME:  busRdata = {4'b0, tProg, tRd, tRelax, tWait};
      A_RDCTL: begin
        busRdata[0] = readFuse;
        busRdata[4 +: NUM_W] = readNum;
      end
      A_DATA:  busRdata = dataReg;
      A_STAT:  begin
        busRdata[3:0] = {lockedFlag, progFail, errFlag, ctl.busy};
        busRdata[4 +: READ_WORDS] = ded;
      end
      default: begin
        for (int k = 0; k < READ_WORDS; k++)
          if (busAddr == BUS_AW'(RDATA_BASE + k)) busRdata = readData[k];
        for (int i = 0; i < FUSE_WORDS; i++)
          if (busAddr == BUS_AW'(SHADOW_BASE + i)) busRdata = shadow[i];
      end
    endcase
  end

  // R1, R12: fuse contents only move on a program word step
  a_r1_fuse_stable: assert property (@(posedge clk) disable iff (!rstN)
    !isProgDone |=> $stable(fuseData));
  // R3: the reload trigger is only visible while the sequencer is busy
  a_r3_reload_busy: assert property (@(posedge clk) disable iff (!rstN)
    reloadBit |-> ctl.busy);
  // R10: key is gone after each program step
  a_r10_key_dropped: assert property (@(posedge clk) disable iff (!rstN)
    isProgDone |=> unlockKey == 16'h0);
  // R8: an uncorrectable flag rises only after a read word step
  a_r8_ded_after_read: assert property (@(posedge clk) disable iff (!rstN)
    ((ded & ~$past(ded)) != '0) |-> $past(isReadDone));
endmodule

// File: rtl/fuse_sequencer.sv
`timescale 1ns/1ps
module fuse_sequencer
  import fuse_pkg::*;
#(
  parameter int FUSE_WORDS = 16,
  parameter int READ_WORDS = 2,
  parameter int BUS_AW     = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [BUS_AW-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busy,
  output logic              readStrobe,
  output logic              progStrobe
);
  ctlStrobe_t ctl;
  opKind_t    launchKind;
  logic       lastWord;
  logic [7:0] tRd, tProg, tWait;
  logic [3:0] tRelax;

  fuse_datapath #(.FUSE_WORDS(FUSE_WORDS), .READ_WORDS(READ_WORDS), .BUS_AW(BUS_AW)) dp (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .ctl(ctl), .launchKind(launchKind), .lastWord(lastWord),
    .tRd(tRd), .tProg(tProg), .tRelax(tRelax), .tWait(tWait));

  fuse_control #(.STROBE_W(8), .RELAX_W(4), .WAIT_W(8)) seq (
    .clk(clk), .rstN(rstN), .launchKind(launchKind), .lastWord(lastWord),
    .rdLen(tRd), .progLen(tProg), .relaxLen(tRelax), .waitLen(tWait),
    .ctl(ctl), .readStrobe(readStrobe), .progStrobe(progStrobe));

  assign busy = ctl.busy;
endmodule

// File: tb/fuse_sequencer_test.sv
`timescale 1ns/1ps
module fuse_sequencer_test;
  localparam logic [5:0] CTRL = 6'd0, CSET = 6'd1, CCLR = 6'd2, TIMING = 6'd3, RDCTL = 6'd4,
    DATA = 6'd5, STATUS = 6'd6, STCLR = 6'd7, RDAT = 6'd8, SHAD = 6'd32;
  localparam logic [31:0] KEY = 32'h3E77_0000;
  localparam logic [31:0] TBASE = (32'd9 << 20) | (32'd3 << 12) | 32'd1;

  logic clk = 1'b0;
  logic rstN, busWr, busy, readStrobe, progStrobe;
  logic [5:0] busAddr;
  logic [31:0] busWdata, busRdata;
  logic [31:0] model [16];
  int nChk = 0, nFail = 0;

  always #2.5 clk = ~clk;

  fuse_sequencer uut (.clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busy(busy), .readStrobe(readStrobe),
    .progStrobe(progStrobe));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk); busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); busAddr = a; #1; d = busRdata;
  endtask

  // called on the negedge right after a launching write
  task automatic runOp(output int bn, output int rn, output int pn, output int fi);
    bn = 0; rn = 0; pn = 0; fi = -1;
    while (busy && bn < 5000) begin
      if (readStrobe || progStrobe) begin
        if (fi < 0) fi = bn;
        if (readStrobe) rn++;
        if (progStrobe) pn++;
      end
      bn++;
      @(negedge clk);
    end
  endtask

  task automatic readWord(input int a, output logic [31:0] d);
    int bn, rn, pn, fi;
    wr(CTRL, 32'(a)); wr(RDCTL, 32'd1); runOp(bn, rn, pn, fi);
    rdReg(RDAT, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL R11 watchdog actual=timeout expected=completion");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int bn, rn, pn, fi;
    int da [3] = '{1, 2, 4};
    busWr = 1'b0; busAddr = '0; busWdata = '0; rstN = 1'b0;
    for (int i = 0; i < 16; i++) model[i] = 32'h0101_0101 * 32'(i);
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R13 reset state
    rdReg(CTRL, v);   chk("R13 ctrl", v, 32'h0);
    rdReg(TIMING, v); chk("R13 timing", v, 32'h0090_3001);
    rdReg(RDCTL, v);  chk("R13 rdctl", v, 32'h0);
    rdReg(STATUS, v); chk("R13 status", v, 32'h0);
    rdReg(SHAD + 6'd5, v); chk("R13 shadow", v, 32'h0);

    // R4 R5 R11 timing sweep on single-word reads
    for (int r = 0; r < 3; r++)
      for (int j = 0; j < 3; j++)
        for (int w = 0; w < 3; w++) begin
          int s;
          s = 2 * r + 1 + da[j];
          wr(TIMING, (32'd9 << 20) | (32'(s) << 12) | (32'(r) << 8) | 32'(w));
          wr(CTRL, 32'd1); wr(RDCTL, 32'd1);
          runOp(bn, rn, pn, fi);
          chk("R11 busy length", 32'(bn), 32'(s + 1 + w + 1));
          chk("R5 strobe width", 32'(rn), 32'(da[j]));
          chk("R5 relax lead", 32'(fi), 32'(r + 1));
          chk("R4 no prog strobe on read", 32'(pn), 32'd0);
        end

    // R6 R8 read sweep over all addresses and counts
    wr(TIMING, TBASE);
    for (int a = 0; a < 16; a++)
      for (int n = 0; n < 2; n++) begin
        logic [31:0] dedExp;
        dedExp = 32'h0;
        wr(STCLR, 32'hF0); wr(CTRL, 32'(a)); wr(RDCTL, (32'(n) << 4) | 32'd1);
        runOp(bn, rn, pn, fi);
        chk("R11 multiword busy", 32'(bn), 32'((n + 1) * 4 + 2));
        for (int k = 0; k <= n; k++) begin
          rdReg(RDAT + 6'(k), v);
          chk("R6 read word", v, model[(a + k) % 16]);
          if ((a + k) % 16 == 6) dedExp[4 + k] = 1'b1;
        end
        rdReg(STATUS, v); chk("R8 check flags", v, dedExp);
        rdReg(RDCTL, v);  chk("R6 read bit clears", v, 32'(n) << 4);
      end
    wr(STCLR, 32'hF0);

    // R1 R10 successful program
    wr(CTRL, KEY | 32'd3); wr(DATA, 32'h00F0_0F00);
    runOp(bn, rn, pn, fi);
    model[3] = model[3] | 32'h00F0_0F00;
    chk("R11 program busy", 32'(bn), 32'd12);
    chk("R5 program strobe width", 32'(pn), 32'd8);
    chk("R4 no read strobe on program", 32'(rn), 32'd0);
    rdReg(CTRL, v);   chk("R10 key cleared after success", v, 32'd3);
    rdReg(STATUS, v); chk("R7 no flags on success", v, 32'h0);
    rdReg(SHAD + 6'd3, v); chk("R3 shadow waits for reload", v, 32'h0);
    readWord(3, v); chk("R1 programmed word", v, model[3]);

    // R12 data write without key
    wr(CTRL, 32'd4); wr(DATA, 32'hFFFF_FFFF);
    chk("R12 no launch", 32'(busy), 32'd0);
    rdReg(STATUS, v); chk("R12 error flag", v, 32'h2);
    wr(STCLR, 32'h2);
    rdReg(STATUS, v); chk("R2 error clears", v, 32'h0);
    readWord(4, v); chk("R12 word untouched", v, model[4]);

    // R7 second program and locked word
    wr(CTRL, KEY | 32'd3); wr(DATA, 32'h0000_00FF); runOp(bn, rn, pn, fi);
    rdReg(STATUS, v); chk("R7 program fail", v, 32'h4);
    rdReg(CTRL, v);   chk("R10 key cleared after fail", v, 32'd3);
    readWord(3, v);   chk("R7 word kept after fail", v, model[3]);
    wr(STCLR, 32'h4);
    wr(CTRL, KEY | 32'd15); wr(DATA, 32'h0000_0001); runOp(bn, rn, pn, fi);
    rdReg(STATUS, v); chk("R7 locked", v, 32'h8);
    rdReg(CTRL, v);   chk("R10 key cleared after lock", v, 32'd15);
    readWord(15, v);  chk("R7 locked word kept", v, model[15]);
    wr(STCLR, 32'h8);
    rdReg(STATUS, v); chk("R7 flags clear", v, 32'h0);

    // R2 overlapped accesses during a long read
    wr(TIMING, (32'd9 << 20) | (32'd60 << 12) | 32'd2);
    wr(CTRL, KEY | 32'd5); wr(RDCTL, 32'd1);
    wr(DATA, 32'hFFFF_0000); wr(CSET, 32'h0000_1008); wr(RDCTL, 32'h11);
    runOp(bn, rn, pn, fi);
    rdReg(STATUS, v); chk("R2 overlap error", v, 32'h2);
    rdReg(CTRL, v);   chk("R2 ctrl write dropped", v, KEY | 32'd5);
    rdReg(RDCTL, v);  chk("R2 rdctl write dropped", v, 32'h0);
    rdReg(RDAT, v);   chk("R2 first read intact", v, model[5]);
    rdReg(SHAD + 6'd5, v); chk("R2 no reload", v, 32'h0);
    wr(STCLR, 32'h2); wr(TIMING, TBASE);
    readWord(5, v); chk("R2 no program", v, model[5]);

    // R9 set and clear aliases
    wr(CTRL, 32'h0); wr(CSET, 32'h5);
    rdReg(CTRL, v); chk("R9 set", v, 32'h5);
    wr(CSET, 32'h2);
    rdReg(CTRL, v); chk("R9 set or", v, 32'h7);
    wr(CCLR, 32'h1);
    rdReg(CTRL, v); chk("R9 clear", v, 32'h6);
    wr(CSET, KEY);
    rdReg(CTRL, v); chk("R9 set key", v, KEY | 32'h6);
    wr(CCLR, 32'hFFFF_0000);
    rdReg(CTRL, v); chk("R9 clear key", v, 32'h6);
    wr(CTRL, 32'h9);
    rdReg(CTRL, v); chk("R9 plain write", v, 32'h9);

    // R3 bulk reload
    wr(CSET, 32'h0000_1000);
    busAddr = CTRL; #1; v = busRdata;
    chk("R3 reload bit set", v, 32'h1009);
    runOp(bn, rn, pn, fi);
    chk("R11 reload busy", 32'(bn), 32'(16 * 4 + 2));
    rdReg(CTRL, v); chk("R3 reload bit clears", v, 32'h9);
    for (int i = 0; i < 16; i++) begin
      rdReg(SHAD + 6'(i), v);
      chk("R3 shadow copy", v, model[i]);
    end

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule